// File: doc/BRIEF.md
# Protection Entry Address and Mode Register with Granularity Masking

This block holds a single memory-protection entry as seen by software: an 8-bit configuration byte and an XLEN-wide address register. Both are reached through a small control-register port that offers plain write, bit-set and bit-clear operations. The address register follows a fixed granularity exponent `G`. Stored bits below `G` are trimmed, and the low bits that software reads back depend on the addressing mode held in the configuration byte.

One detail matters most. Address bit `G-1` is always kept in storage but is hidden, reading as zero, whenever the mode is anything other than naturally-aligned power-of-two. Set and clear operations merge their data into the value software would read, not into the raw stored value. So a set or clear that targets other bits while the bit is hidden writes a zero into it. Software can find `G` by clearing the configuration byte, writing all ones to the address register and locating the lowest set bit of the readback. The region granularity is then 2^(G+2) bytes.

Read data is combinational on the selected register address. A write takes effect at the clock edge that ends the access cycle.

Top module: `pmp_gran_csr`

## Requirements
- R1: While `rst` is high at a rising edge, the configuration byte becomes 0x00 (mode OFF) and the stored address becomes zero. Both registers then read as zero.
- R2: A plain write (op code 1) stores the write data. On the configuration address only `csr_wdata[7:0]` is kept, and it reads back zero-extended. The mode field is bits 4:3 of that byte: 00 is OFF, 01 is TOR, 10 is NA4 and 11 is NAPOT.
- R3: In any mode other than NAPOT, address bits G-1 down to 0 read as zero. The stored value of bit G-1 is kept and shows again after a switch to NAPOT.
- R4: In NAPOT mode, address bit G-1 reads its stored value and bits G-2 down to 0 read as ones. Bits G and above always read as stored.
- R5: A write or set that changes address bit G-1 updates its stored value in every mode, including OFF.
- R6: Set (op code 2) stores the visible value OR the data. Clear (op code 3) stores the visible value AND the inverted data. As a result, a set of other bits while bit G-1 is hidden stores a zero in it.
- R7: A set or clear with `csr_src_zero` high writes nothing to either register, whatever the data.
- R8: `csr_src_zero` has no effect on a plain write.
- R9: With the configuration byte at zero, writing all ones to the address register reads back with the lowest set bit at index G.
- R10: An address other than the two register addresses reads as zero, and an access to it changes neither register.
- R11: Read data follows the current address and register state in the same cycle. A write becomes visible in the cycle after the access.
- R12: Op code 0 (read) never changes either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | Access strobe; a write-type op commits at the next rising edge |
| csr_addr | input | 12 | Register address; selects configuration, address or neither |
| csr_op | input | 2 | 0 read, 1 write, 2 set bits, 3 clear bits |
| csr_wdata | input | XLEN | Write, set or clear data |
| csr_src_zero | input | 1 | Source operand is the zero register; suppresses set and clear |
| csr_rdata | output | XLEN | Visible value of the addressed register, combinational |

## Verification
Every result of an access is due one clock after it. The new stored value appears at the rising edge that closes the access cycle, and the readback is combinational from there. The bench drives each access on a falling edge and drops the strobe on the next falling edge. It then sets the read address and samples one nanosecond later, well clear of any rising edge. One directed test also samples during the access cycle itself to confirm that the old value is still visible before that edge.

// File: rtl/pmpg_pkg.sv
package pmpg_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    localparam int CFG_W     = 8;
    localparam int MODE_LSB  = 3;

    typedef struct packed {
        logic hit_cfg;
        logic hit_addr;
        logic commit;
    } access_t;

    function automatic amode_e cfg_mode(input logic [CFG_W-1:0] cfg);
        return amode_e'(cfg[MODE_LSB+1:MODE_LSB]);
    endfunction

    // Set and clear with a zero source do not write; plain write always does.
    function automatic logic op_writes(input csr_op_e op, input logic src_zero);
        case (op)
            OP_WRITE:           return 1'b1;
            OP_SET, OP_CLEAR:   return !src_zero;
            default:            return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmpg_rmw.sv
module pmpg_rmw
    import pmpg_pkg::*;
#(
    parameter int W = 32
) (
    input  csr_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wd,
    output logic [W-1:0] nxt
);

    always_comb begin
        case (op)
            OP_WRITE: nxt = wd;
            OP_SET:   nxt = cur | wd;
            OP_CLEAR: nxt = cur & ~wd;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/pmpg_cfg_reg.sv
module pmpg_cfg_reg
    import pmpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] d,
    output logic [CFG_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= d;
    end

endmodule

// File: rtl/pmpg_addr_reg.sv
module pmpg_addr_reg #(
    parameter int XLEN = 32,
    parameter int G    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] d,
    input  logic            napot,
    output logic [XLEN-1:0] st_q,
    output logic [XLEN-1:0] view
);

    localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};
    // Bits G and up: always stored, always visible.
    localparam logic [XLEN-1:0] HI_MASK  = {XLEN{1'b1}} << G;
    // Single bit G-1 (zero when G is 0).
    localparam logic [XLEN-1:0] GM1_BIT  = (ONE << G) >> 1;
    // Bits G-2..0 (zero when G < 2).
    localparam logic [XLEN-1:0] LOW_ONES = (GM1_BIT == '0) ? '0 : GM1_BIT - ONE;
    localparam logic [XLEN-1:0] ST_MASK  = HI_MASK | GM1_BIT;

    always_ff @(posedge clk) begin
        if (rst)     st_q <= '0;
        else if (we) st_q <= d & ST_MASK;
    end

    always_comb begin
        view = st_q & HI_MASK;
        if (napot) view = view | (st_q & GM1_BIT) | LOW_ONES;
    end

endmodule

// File: rtl/pmp_gran_csr.sv
module pmp_gran_csr
    import pmpg_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          G        = 4,
    parameter logic [11:0] CFG_CSR  = 12'h3A0,
    parameter logic [11:0] ADDR_CSR = 12'h3B0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            csr_en,
    input  logic [11:0]     csr_addr,
    input  logic [1:0]      csr_op,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_src_zero,
    output logic [XLEN-1:0] csr_rdata
);

    if (G < 0 || G > XLEN - 1 || XLEN <= CFG_W) begin : g_bad_param
        $error("pmp_gran_csr: G must lie in 0..XLEN-1 and XLEN must exceed 8");
    end

    csr_op_e          op;
    access_t          acc;
    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg_nxt;
    logic [XLEN-1:0]  addr_st;
    logic [XLEN-1:0]  addr_view;
    logic [XLEN-1:0]  addr_nxt;
    logic             napot;

    assign op           = csr_op_e'(csr_op);
    assign acc.hit_cfg  = (csr_addr == CFG_CSR);
    assign acc.hit_addr = (csr_addr == ADDR_CSR);
    assign acc.commit   = csr_en && op_writes(op, csr_src_zero);
    assign napot        = (cfg_mode(cfg_q) == AM_NAPOT);

    pmpg_rmw #(.W(CFG_W)) u_cfg_rmw (
        .op  (op),
        .cur (cfg_q),
        .wd  (csr_wdata[CFG_W-1:0]),
        .nxt (cfg_nxt)
    );

    pmpg_cfg_reg u_cfg (
        .clk (clk),
        .rst (rst),
        .we  (acc.commit && acc.hit_cfg),
        .d   (cfg_nxt),
        .q   (cfg_q)
    );

    // Merge against the visible value, so hidden bits fold back in as read.
    pmpg_rmw #(.W(XLEN)) u_addr_rmw (
        .op  (op),
        .cur (addr_view),
        .wd  (csr_wdata),
        .nxt (addr_nxt)
    );

    pmpg_addr_reg #(.XLEN(XLEN), .G(G)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .we    (acc.commit && acc.hit_addr),
        .d     (addr_nxt),
        .napot (napot),
        .st_q  (addr_st),
        .view  (addr_view)
    );

    always_comb begin
        if (acc.hit_cfg)       csr_rdata = {{(XLEN-CFG_W){1'b0}}, cfg_q};
        else if (acc.hit_addr) csr_rdata = addr_view;
        else                   csr_rdata = '0;
    end

endmodule

// File: rtl/pmp_gran_csr_chk.sv
module pmp_gran_csr_chk #(
    parameter int          XLEN     = 32,
    parameter int          G        = 4,
    parameter logic [11:0] CFG_CSR  = 12'h3A0,
    parameter logic [11:0] ADDR_CSR = 12'h3B0
) (
    input logic            clk,
    input logic            rst,
    input logic            csr_en,
    input logic [11:0]     csr_addr,
    input logic [1:0]      csr_op,
    input logic [XLEN-1:0] csr_wdata,
    input logic            csr_src_zero,
    input logic [XLEN-1:0] csr_rdata,
    input logic [7:0]      cfg_q,
    input logic [XLEN-1:0] addr_st
);

    logic sel_cfg, sel_addr, is_napot, setclr;
    assign sel_cfg  = (csr_addr == CFG_CSR);
    assign sel_addr = (csr_addr == ADDR_CSR);
    assign is_napot = (cfg_q[4:3] == 2'b11);
    assign setclr   = (csr_op == 2'd2) || (csr_op == 2'd3);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && addr_st == '0)); // R1

    AST_ZERO_SRC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (csr_en && setclr && csr_src_zero) |=> ($stable(cfg_q) && $stable(addr_st))); // R7

    AST_READ_OP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (csr_en && csr_op == 2'd0) |=> ($stable(cfg_q) && $stable(addr_st))); // R12

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!sel_cfg && !sel_addr) |-> (csr_rdata == '0)); // R10

    AST_UNMAPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (csr_en && !sel_cfg && !sel_addr) |=> ($stable(cfg_q) && $stable(addr_st))); // R10

    AST_CFG_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        sel_cfg |-> (csr_rdata[XLEN-1:8] == '0 && csr_rdata[7:0] == cfg_q)); // R2

    if (G > 0) begin : g_gm1
        AST_HIDDEN_IN_OFF: assert property (@(posedge clk) disable iff (rst)
            (sel_addr && !is_napot) |-> (csr_rdata[G-1:0] == '0)); // R3

        AST_NAPOT_SHOWS_BIT: assert property (@(posedge clk) disable iff (rst)
            (sel_addr && is_napot) |-> (csr_rdata[G-1] == addr_st[G-1])); // R4

        AST_WRITE_LANDS_GM1: assert property (@(posedge clk) disable iff (rst)
            (csr_en && sel_addr && csr_op == 2'd1) |=> (addr_st[G-1] == $past(csr_wdata[G-1]))); // R5
    end

endmodule

bind pmp_gran_csr pmp_gran_csr_chk #(
    .XLEN(XLEN), .G(G), .CFG_CSR(CFG_CSR), .ADDR_CSR(ADDR_CSR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .csr_en       (csr_en),
    .csr_addr     (csr_addr),
    .csr_op       (csr_op),
    .csr_wdata    (csr_wdata),
    .csr_src_zero (csr_src_zero),
    .csr_rdata    (csr_rdata),
    .cfg_q        (cfg_q),
    .addr_st      (addr_st)
);

// File: tb/pmp_gran_csr_test.sv
module pmp_gran_csr_test;

    localparam int          XLEN = 32;
    localparam int          G    = 4;
    localparam logic [11:0] CFGA = 12'h3A0;
    localparam logic [11:0] ADRA = 12'h3B0;
    localparam logic [11:0] NONE = 12'h7C0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            csr_en = 1'b0;
    logic [11:0]     csr_addr = 12'h0;
    logic [1:0]      csr_op = 2'd0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic            csr_src_zero = 1'b0;
    logic [XLEN-1:0] csr_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pmp_gran_csr #(.XLEN(XLEN), .G(G), .CFG_CSR(CFGA), .ADDR_CSR(ADRA)) uut (
        .clk          (clk),
        .rst          (rst),
        .csr_en       (csr_en),
        .csr_addr     (csr_addr),
        .csr_op       (csr_op),
        .csr_wdata    (csr_wdata),
        .csr_src_zero (csr_src_zero),
        .csr_rdata    (csr_rdata)
    );

    // sel: 0 config byte, 1 address register, 2 unmapped
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  sel;
        logic [31:0] wd;
        logic        zs;
        logic [31:0] exp_addr;
        logic [7:0]  exp_cfg;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd1, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFF0, 8'h00, 8'd9},  // R9 lowest set bit at G
        '{2'd2, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFFF, 8'h18, 8'd4},  // R4 napot shows low ones
        '{2'd3, 2'd1, 32'h00000008, 1'b0, 32'hFFFFFFF7, 8'h18, 8'd6},  // R6 clear bit G-1
        '{2'd2, 2'd1, 32'h00000008, 1'b0, 32'hFFFFFFFF, 8'h18, 8'd6},  // R6 set bit G-1
        '{2'd3, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFF0, 8'h00, 8'd3},  // R3 off hides
        '{2'd2, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFFF, 8'h18, 8'd3},  // R3 stored bit kept
        '{2'd3, 2'd1, 32'h00000008, 1'b0, 32'hFFFFFFF7, 8'h18, 8'd6},
        '{2'd3, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFF0, 8'h00, 8'd3},
        '{2'd2, 2'd1, 32'h00000008, 1'b0, 32'hFFFFFFF0, 8'h00, 8'd5},  // R5 set while hidden
        '{2'd2, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFFF, 8'h18, 8'd5},  // R5 it landed
        '{2'd3, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFF0, 8'h00, 8'd3},
        '{2'd3, 2'd1, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFF0, 8'h00, 8'd7},  // R7 clear from zero reg
        '{2'd2, 2'd1, 32'h00001234, 1'b1, 32'hFFFFFFF0, 8'h00, 8'd7},  // R7 set from zero reg
        '{2'd2, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFFF, 8'h18, 8'd7},  // R7 hidden bit intact
        '{2'd3, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFF0, 8'h00, 8'd3},
        '{2'd2, 2'd1, 32'hFFFFFFF7, 1'b0, 32'hFFFFFFF0, 8'h00, 8'd6},  // R6 set others while hidden
        '{2'd2, 2'd0, 32'h00000018, 1'b0, 32'hFFFFFFF7, 8'h18, 8'd6},  // R6 hidden bit now zero
        '{2'd1, 2'd1, 32'h12345670, 1'b0, 32'h12345677, 8'h18, 8'd2},  // R2 plain write
        '{2'd1, 2'd0, 32'h00000008, 1'b0, 32'h12345670, 8'h08, 8'd3},  // R3 tor masks low bits
        '{2'd1, 2'd1, 32'h0000000F, 1'b0, 32'h00000000, 8'h08, 8'd3},
        '{2'd1, 2'd0, 32'hABCDEF18, 1'b0, 32'h0000000F, 8'h18, 8'd2},  // R2 byte kept, zero-extended
        '{2'd1, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h0000000F, 8'h18, 8'd10}, // R10 unmapped ignored
        '{2'd0, 2'd1, 32'hFFFFFFFF, 1'b0, 32'h0000000F, 8'h18, 8'd12}, // R12 read op
        '{2'd1, 2'd1, 32'h00000100, 1'b1, 32'h00000107, 8'h18, 8'd8}   // R8 zero flag on write
    };

    function automatic logic [11:0] sel_addr(input logic [1:0] s);
        return (s == 2'd0) ? CFGA : (s == 2'd1) ? ADRA : NONE;
    endfunction

    task automatic apply(input logic [1:0] op, input logic [11:0] a,
                         input logic [31:0] wd, input logic zs);
        @(negedge clk);
        csr_en = 1'b1; csr_op = op; csr_addr = a; csr_wdata = wd; csr_src_zero = zs;
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd0; csr_wdata = '0; csr_src_zero = 1'b0;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [31:0] exp,
                             input int req, input string what);
        csr_addr = a;
        #1;
        checks++;
        if (csr_rdata !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, csr_rdata, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        expect_rd(CFGA, 32'h0, 1, "cfg after reset");
        expect_rd(ADRA, 32'h0, 1, "addr after reset");
        rst = 1'b0;
        // R10 unmapped reads zero
        expect_rd(NONE, 32'h0, 10, "unmapped read");

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, sel_addr(VECS[i].sel), VECS[i].wd, VECS[i].zs);
            expect_rd(ADRA, VECS[i].exp_addr, int'(VECS[i].req), $sformatf("row %0d addr", i));
            expect_rd(CFGA, {24'h0, VECS[i].exp_cfg}, int'(VECS[i].req), $sformatf("row %0d cfg", i));
        end
        expect_rd(NONE, 32'h0, 10, "unmapped read after writes");

        // R11: old value during the access cycle, new value one cycle later
        @(negedge clk);
        csr_en = 1'b1; csr_op = 2'd1; csr_addr = ADRA; csr_wdata = 32'h00000200;
        #1;
        checks++;
        if (csr_rdata !== 32'h00000107) begin
            errors++;
            $display("FAIL R11 before edge: actual %h expected %h", csr_rdata, 32'h00000107);
        end
        @(negedge clk);
        csr_en = 1'b0; csr_op = 2'd0; csr_wdata = '0;
        expect_rd(ADRA, 32'h00000207, 11, "after edge");

        // R4 and R3 with bit G-1 set in a mapped write, then NA4 mode hides it
        apply(2'd1, ADRA, 32'h0000ABC8, 1'b0);
        expect_rd(ADRA, 32'h0000ABCF, 4, "napot bit G-1 set");
        apply(2'd1, CFGA, 32'h00000010, 1'b0);
        expect_rd(ADRA, 32'h0000ABC0, 3, "na4 hides low bits");

        // R1 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_rd(CFGA, 32'h0, 1, "cfg after second reset");
        expect_rd(ADRA, 32'h0, 1, "addr after second reset");

        finish_run();
    end

endmodule